// File: doc/BRIEF.md
# Gated Clock Fanout with Source Select

This block distributes one of two clocks to six output pairs. A select input chooses between a fast primary clock and a slower scan/test clock. Each output pair has a true output and a complement output. A shared enable and six per-pair enables, all active low, decide which pairs toggle.

Enables do not act directly. Each pair has a small gate state machine that is clocked on the falling edge of the selected clock. An enable change therefore takes effect only while the clock is low, and a true output is never cut short during its high phase.

Each pair's state machine has two states. `GATE_OFF` holds the true output low and the complement high. `GATE_ON` passes the selected clock through. At every falling edge the machine takes one of four transitions:
- ARM: `GATE_OFF` to `GATE_ON`, when the pair's run request is present.
- PARK: `GATE_ON` to `GATE_OFF`, when the run request is absent.
- HOLD: stays in the same state, when the run request matches the current state.
- CLEAR: goes to `GATE_OFF`, when reset is asserted.

A parameter keeps or removes the synchronous reset. When the reset is kept, the state after power-up is defined.

Top module: `gated_clk_fanout`

## Requirements
- R1: With `clk_sel` = 0 the enabled outputs follow `sys_clk`. With `clk_sel` = 1 they follow `test_clk`, and `sys_clk` has no effect on the outputs.
- R2: Output pair i runs when `all_en_n` = 0 and `out_en_n[i]` = 0, as captured at the last falling edge of the selected clock. A 1 on `all_en_n` stops every pair, whatever the per-pair enables are.
- R3: Enables are sampled only at the falling edge of the selected clock. An enable change during a high phase leaves the outputs of that high phase unchanged.
- R4: A stopped pair holds `clk_q[i]` = 0 and `clk_qn[i]` = 1.
- R5: `clk_qn` is always the bitwise inverse of `clk_q`.
- R6: With the default reset enabled, `rst_n` = 0 at a falling edge of the selected clock stops every pair, whatever the enables are.
- R7: While the selected clock is low, every `clk_q` bit is 0. Every high pulse on a `clk_q` bit lasts exactly one full high phase of the selected clock.
- R8: Bit i of `out_en_n` controls only output pair i (bit 0 controls `clk_q[0]`/`clk_qn[0]`, bit 5 controls `clk_q[5]`/`clk_qn[5]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Primary system clock |
| test_clk | input | 1 | Slower scan/test clock |
| clk_sel | input | 1 | Source select: 0 = `sys_clk`, 1 = `test_clk` |
| rst_n | input | 1 | Synchronous active-low reset, sampled on the falling edge of the selected clock |
| all_en_n | input | 1 | Shared enable, active low |
| out_en_n | input | NUM_OUT (6) | Per-pair enables, active low |
| clk_q | output | NUM_OUT (6) | True clock outputs |
| clk_qn | output | NUM_OUT (6) | Complement clock outputs |

## Verification
The bench changes the enables 3 ns after a rising edge of the selected clock.
- At rising edge + 4 ns, while the clock is still high, the outputs must still show the old gating.
- Within the next low phase, 2 ns after the falling edge, every true output must be 0.
- From the next rising edge, the new gating is due. The bench samples it 2 ns after that rising edge.

A scoreboard queue carries each expected mask from the driver to the monitor, and the monitor waits for exactly those edges. A separate monitor times every high pulse on each true output against the half-period of the selected clock. The bench moves the select input only while both clocks are low.

// File: rtl/cfo_pkg.sv
`timescale 1ns/1ps
package cfo_pkg;

    // Gate state of one output pair
    typedef enum logic [0:0] {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_state_e;

endpackage

// File: rtl/cfo_clk_sel.sv
`timescale 1ns/1ps
// Two-way clock source selection; changes of sel are expected while both clocks are low
module cfo_clk_sel (
    input  logic sys_clk,
    input  logic test_clk,
    input  logic sel,
    output logic clk_out
);

    always_comb begin
        unique case (sel)
            1'b1:    clk_out = test_clk;
            default: clk_out = sys_clk;
        endcase
    end

endmodule

// File: rtl/cfo_en_decode.sv
`timescale 1ns/1ps
// Merges the shared active-low enable with the per-pair active-low enables
module cfo_en_decode #(
    parameter int NUM_OUT = 6
) (
    input  logic               all_en_n,
    input  logic [NUM_OUT-1:0] out_en_n,
    output logic [NUM_OUT-1:0] run_req
);

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_req
        assign run_req[g] = ~all_en_n & ~out_en_n[g];
    end

endmodule

// File: rtl/cfo_gate_ch.sv
`timescale 1ns/1ps
// One output pair: falling-edge gate state machine plus output gating
module cfo_gate_ch
    import cfo_pkg::*;
#(
    parameter bit HAS_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    output logic q,
    output logic qn
);

    gate_state_e state_q;
    gate_state_e state_d;

    // State register: updates only while the clock goes low
    always_ff @(negedge clk) begin
        if (HAS_RESET && !rst_n) begin
            state_q <= GATE_OFF;              // CLEAR
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        unique case (state_q)
            GATE_OFF: state_d = run_req ? GATE_ON  : GATE_OFF; // ARM / HOLD
            GATE_ON:  state_d = run_req ? GATE_ON  : GATE_OFF; // HOLD / PARK
            default:  state_d = GATE_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            GATE_ON: begin
                q  = clk;
                qn = ~clk;
            end
            default: begin
                q  = 1'b0;
                qn = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/gated_clk_fanout.sv
`timescale 1ns/1ps
module gated_clk_fanout #(
    parameter int NUM_OUT   = 6,
    parameter bit HAS_RESET = 1'b1
) (
    input  logic               sys_clk,
    input  logic               test_clk,
    input  logic               clk_sel,
    input  logic               rst_n,
    input  logic               all_en_n,
    input  logic [NUM_OUT-1:0] out_en_n,
    output logic [NUM_OUT-1:0] clk_q,
    output logic [NUM_OUT-1:0] clk_qn
);

    logic               clk_mux;
    logic [NUM_OUT-1:0] run_req;

    cfo_clk_sel u_sel (
        .sys_clk (sys_clk),
        .test_clk(test_clk),
        .sel     (clk_sel),
        .clk_out (clk_mux)
    );

    cfo_en_decode #(
        .NUM_OUT(NUM_OUT)
    ) u_dec (
        .all_en_n(all_en_n),
        .out_en_n(out_en_n),
        .run_req (run_req)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_ch
        cfo_gate_ch #(
            .HAS_RESET(HAS_RESET)
        ) u_ch (
            .clk    (clk_mux),
            .rst_n  (rst_n),
            .run_req(run_req[g]),
            .q      (clk_q[g]),
            .qn     (clk_qn[g])
        );
    end

endmodule

// File: rtl/gated_clk_fanout_chk.sv
`timescale 1ns/1ps
module gated_clk_fanout_chk #(
    parameter int NUM_OUT   = 6,
    parameter bit HAS_RESET = 1'b1
) (
    input logic               clk_mux,
    input logic               rst_n,
    input logic               all_en_n,
    input logic [NUM_OUT-1:0] out_en_n,
    input logic [NUM_OUT-1:0] clk_q,
    input logic [NUM_OUT-1:0] clk_qn
);

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_pair
        // Enabled at a falling edge: high for the whole next high phase
        p_run_r2: assert property (@(negedge clk_mux) disable iff (!rst_n)
            (!all_en_n && !out_en_n[g]) |=> clk_q[g]);

        // Disabled at a falling edge: true output low and complement high
        p_stop_r4: assert property (@(negedge clk_mux) disable iff (!rst_n)
            (all_en_n || out_en_n[g]) |=> (!clk_q[g] && clk_qn[g]));
    end

    // Complement pairs, sampled during the high phase
    p_compl_r5: assert property (@(negedge clk_mux) disable iff (!rst_n)
        clk_qn == ~clk_q);

    // No true output is high while the selected clock is low
    p_low_r7: assert property (@(posedge clk_mux) disable iff (!rst_n)
        clk_q == '0);

    if (HAS_RESET) begin : g_rst
        p_reset_r6: assert property (@(negedge clk_mux)
            (rst_n == 1'b0) |=> (clk_q == '0));
    end

endmodule

bind gated_clk_fanout gated_clk_fanout_chk #(
    .NUM_OUT  (NUM_OUT),
    .HAS_RESET(HAS_RESET)
) u_chk (
    .clk_mux (clk_mux),
    .rst_n   (rst_n),
    .all_en_n(all_en_n),
    .out_en_n(out_en_n),
    .clk_q   (clk_q),
    .clk_qn  (clk_qn)
);

// File: tb/gated_clk_fanout_tb.sv
`timescale 1ns/1ps
module gated_clk_fanout_tb;

    localparam int N = 6;

    logic         sys_clk  = 1'b0;
    logic         test_clk = 1'b0;
    logic         clk_sel  = 1'b0;
    logic         rst_n    = 1'b0;
    logic         all_en_n = 1'b0;
    logic [N-1:0] out_en_n = '0;
    logic [N-1:0] clk_q;
    logic [N-1:0] clk_qn;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // 50 MHz primary clock, 12.5 MHz test clock
    always #10 sys_clk  = ~sys_clk;
    always #40 test_clk = ~test_clk;

    wire ref_clk = clk_sel ? test_clk : sys_clk;

    gated_clk_fanout u_dut (
        .sys_clk (sys_clk),
        .test_clk(test_clk),
        .clk_sel (clk_sel),
        .rst_n   (rst_n),
        .all_en_n(all_en_n),
        .out_en_n(out_en_n),
        .clk_q   (clk_q),
        .clk_qn  (clk_qn)
    );

    typedef struct {
        logic [N-1:0] mask;
        logic [N-1:0] prev;
        string        req;
    } exp_t;

    exp_t         sb_q[$];
    int           done_cnt  = 0;
    logic [N-1:0] last_mask = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: change enables in a high phase, push the expected mask
    task automatic drive(input logic cen, input logic [N-1:0] en, input string req);
        exp_t it;
        int   target;
        @(posedge ref_clk);
        #3;
        all_en_n = cen;
        out_en_n = en;
        it.mask  = cen ? '0 : ~en;
        it.prev  = last_mask;
        it.req   = req;
        last_mask = it.mask;
        target = done_cnt + 1;
        sb_q.push_back(it);
        wait (done_cnt == target);
    endtask

    // Monitor: compare at the cycles the requirements fix
    initial begin
        forever begin
            exp_t it;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            #1;
            check(clk_q == it.prev, "R3", "old gating held in current high phase", clk_q, it.prev);
            @(negedge ref_clk);
            #2;
            check(clk_q == '0, "R7", "true outputs low in low phase", clk_q, '0);
            @(posedge ref_clk);
            #2;
            check(clk_q == it.mask, it.req, "true outputs after capture", clk_q, it.mask);
            check(clk_qn == ~it.mask, "R4", "complement outputs after capture", clk_qn, ~it.mask);
            check(clk_qn == ~clk_q, "R5", "complement is inverse", clk_qn, ~clk_q);
            done_cnt++;
        end
    end

    // Pulse-width monitor: every high pulse lasts one full high phase (R7)
    logic [N-1:0] q_prev  = '0;
    bit   [N-1:0] seen_hi = '0;
    time          t_rise[N];
    always @(clk_q) begin
        for (int i = 0; i < N; i++) begin
            if (clk_q[i] && !q_prev[i]) begin
                t_rise[i]  = $time;
                seen_hi[i] = 1'b1;
            end else if (!clk_q[i] && q_prev[i] && seen_hi[i]) begin
                time w;
                time ew;
                w  = $time - t_rise[i];
                ew = clk_sel ? 40 : 10;
                checks++;
                if (w != ew) begin
                    errors++;
                    $display("FAIL R7 pulse width on output %0d: actual %0t expected %0t", i, w, ew);
                end
            end
        end
        q_prev = clk_q;
    end

    // Watchdog
    initial begin
        #4_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        // Reset held with enables asserted (R6)
        repeat (3) @(negedge ref_clk);
        @(posedge ref_clk);
        #2;
        check(clk_q == '0, "R6", "reset stops all true outputs", clk_q, '0);
        check(clk_qn == '1, "R6", "reset holds complements high", clk_qn, '1);
        #1;
        rst_n = 1'b1;
        @(negedge ref_clk);
        last_mask = '1;

        // Primary clock selected (R1)
        drive(1'b0, 6'b000000, "R1");
        drive(1'b0, 6'b101010, "R2");
        drive(1'b1, 6'b000000, "R2");
        drive(1'b0, 6'b111110, "R8");
        drive(1'b0, 6'b011111, "R8");
        drive(1'b1, 6'b111111, "R4");
        drive(1'b0, 6'b000000, "R2");

        // Switch to the test clock while both clocks are low
        @(negedge test_clk);
        #2;
        clk_sel = 1'b1;
        drive(1'b0, 6'b001100, "R1");
        drive(1'b0, 6'b000000, "R1");

        // Primary clock high while test clock low: no effect (R1)
        @(negedge test_clk);
        @(posedge sys_clk);
        #2;
        check(clk_q == '0, "R1", "primary clock ignored when test clock selected", clk_q, '0);

        // Reset during operation (R6)
        @(posedge ref_clk);
        #3;
        rst_n = 1'b0;
        @(negedge ref_clk);
        @(posedge ref_clk);
        #2;
        check(clk_q == '0, "R6", "reset while enabled stops outputs", clk_q, '0);
        #1;
        rst_n = 1'b1;
        @(negedge ref_clk);
        last_mask = '1;

        // Back to the primary clock
        @(negedge test_clk);
        #2;
        clk_sel = 1'b0;
        drive(1'b0, 6'b110000, "R8");
        drive(1'b0, 6'b000000, "R1");

        repeat (4) @(posedge ref_clk);
        finished = 1'b1;
        finish_run();
    end

endmodule